// File: doc/BRIEF.md
# Dual-Channel PWM Slice

This block is one pulse-width-modulation slice. A single 16-bit counter serves two outputs, A and B. Each output compares the counter against its own level and can be inverted. The counter does not step on every clock. A fractional divider with a 4-bit fraction decides when it steps, so the slice can run at non-integer fractions of the system clock while the average rate stays exact.

A write port sets four registers: control, divider, packed levels and the wrap value (TOP). There are two counting modes. Trailing-edge mode counts from 0 to TOP and restarts at 0. Phase-correct mode counts up to TOP, then back down to 0, so the period doubles. TOP and the levels are held in shadow copies. While the slice runs, those copies reload only when a period ends, so a change made mid-period never produces a partial pulse. A wrap pulse marks the end of every period.

Top module: `pwm_slice`

## Requirements
- R1: Register writes use `wr_addr_i` as follows.
  - Address 0 is control: bit 0 enable, bit 1 phase-correct, bit 2 invert A, bit 3 invert B, bits 5:4 divider mode.
  - Address 1 is the divider, bits 11:0, as 8 integer bits over 4 fraction bits.
  - Address 2 holds level A in bits 15:0 and level B in bits 31:16.
  - Address 3 is TOP, bits 15:0.
  - Reset values: control 0, divider 0x010, levels 0, TOP 0xFFFF.
- R2: The counter steps once per divider period of I or I+1 clocks, where I is the integer part. The 4-bit fraction accumulates once per step, and a carry out lengthens the next step by one clock. Over 16 steps the total is exactly 16·I + fraction clocks.
- R3: A divider value below 0x010 behaves as 0x010, which means one step per clock.
- R4: In trailing-edge mode the counter runs 0..TOP and returns to 0, so a period is TOP+1 steps.
- R5: In phase-correct mode the counter runs 0..TOP, holds TOP for one step, runs down to 0 and holds 0 for one step. A period is 2·(TOP+1) steps.
- R6: An output is high while the counter is below its level. Level 0 gives constant low, and a level above TOP gives constant high.
- R7: Each inversion bit flips only its own channel's output.
- R8: While the counter runs, new TOP and level values take effect at the end of the current period. While it is halted, they take effect at once.
- R9: With enable clear, the counter and the divider state freeze, the outputs hold and no wrap pulse occurs.
- R10: `wrap_o` is high for one clock at each period end, and the counter is at 0 in that clock.
- R11: Only divider mode 0 counts. Any other mode halts the counter, as in R9.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Write data |
| pwm_a_o | output | 1 | Channel A waveform |
| pwm_b_o | output | 1 | Channel B waveform |
| wrap_o | output | 1 | One-clock pulse at each period end |

## Verification
A write reaches its register on the first edge after the strobe. The counter steps on the next divider tick, and each output register follows the counter one clock later. `wrap_o` is registered together with the counter, so it goes high in the same clock that the counter reads 0. The bench therefore measures over whole periods, from one wrap pulse to the next, where the one-clock output lag cancels out. It discards the first periods after each reconfiguration. The shadow check counts clocks from the wrap at which TOP was written to the next two wraps: the first gap must match the old TOP and the second the new one.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  parameter int CNT_W      = 16;
  parameter int DIV_INT_W  = 8;
  parameter int DIV_FRAC_W = 4;
  parameter int DATA_W     = 32;
  parameter int ADDR_W     = 2;
  parameter int N_CH       = 2;

  localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;

  typedef struct packed {
    logic [1:0] div_mode;
    logic       inv_b;
    logic       inv_a;
    logic       phase_correct;
    logic       enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_DIV   = 2'd1,
    REG_LEVEL = 2'd2,
    REG_TOP   = 2'd3
  } reg_addr_e;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [INT_W+FRAC_W-1:0] div_i,
  output logic                    tick_o
);
  localparam int LW = INT_W + 1;

  logic [INT_W-1:0]  int_raw, int_eff;
  logic [FRAC_W-1:0] frac_raw, frac_eff;
  logic [LW-1:0]     limit, cyc_q;
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [FRAC_W:0]   acc_sum;

  assign int_raw  = div_i[INT_W+FRAC_W-1:FRAC_W];
  assign frac_raw = div_i[FRAC_W-1:0];

  // values below 1.0 clamp to exactly 1.0 (R3)
  always_comb begin
    if (int_raw == '0) begin
      int_eff  = INT_W'(1);
      frac_eff = '0;
    end else begin
      int_eff  = int_raw;
      frac_eff = frac_raw;
    end
  end

  assign limit   = {1'b0, int_eff} + LW'(extra_q);
  assign tick_o  = run_i && (cyc_q >= limit - LW'(1));
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (run_i) begin
      if (tick_o) begin
        cyc_q   <= '0;
        acc_q   <= acc_sum[FRAC_W-1:0];
        extra_q <= acc_sum[FRAC_W];
      end else begin
        cyc_q <= cyc_q + LW'(1);
      end
    end
  end

  a_r9_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(cyc_q) && $stable(acc_q) && $stable(extra_q)));

  a_r2_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cyc_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_slice_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    tick_i,
  input  logic                    phase_i,
  input  logic [CW-1:0]           top_i,
  input  logic [NCH-1:0][CW-1:0]  lvl_i,
  output logic [CW-1:0]           cnt_o,
  output logic [NCH-1:0][CW-1:0]  lvl_o,
  output logic                    wrap_o
);
  logic [CW-1:0]          cnt_q, cnt_d, top_q;
  logic [NCH-1:0][CW-1:0] lvl_q;
  dir_e                   dir_q, dir_d;
  logic                   end_c, load;
  logic                   wrap_q;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    end_c = 1'b0;
    if (tick_i) begin
      if (!phase_i) begin
        if (cnt_q >= top_q) begin
          cnt_d = '0;
          dir_d = DIR_UP;
          end_c = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= top_q) begin
          cnt_d = top_q;  // hold at top for one step
          dir_d = DIR_DOWN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          dir_d = DIR_UP;
          end_c = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
    end
  end

  // shadows follow registers while halted, else only at period end
  assign load = !run_i || end_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      wrap_q <= 1'b0;
      top_q  <= '1;
      lvl_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      wrap_q <= end_c;
      if (load) begin
        top_q <= top_i;
        lvl_q <= lvl_i;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign lvl_o  = lvl_q;
  assign wrap_o = wrap_q;

  a_r9_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(cnt_q) && !wrap_o));

  a_r10_wrap_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (cnt_q == '0));

  a_r8_shadow_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !end_c) |=> ($stable(top_q) && $stable(lvl_q)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lvl_i,
  input  logic          inv_i,
  output logic          pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= (cnt_i < lvl_i) ^ inv_i;
  end

  assign pwm_o = pwm_q;

  a_r6_zero_level_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |=> (pwm_o == $past(inv_i)));
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              wrap_o
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1 << DIV_FRAC_W);

  ctrl_t                     ctrl_q;
  logic [DIV_W-1:0]          div_q;
  logic [CNT_W-1:0]          top_q;
  logic [N_CH-1:0][CNT_W-1:0] lvl_q, lvl_act;
  logic [CNT_W-1:0]          cnt;
  logic                      run, tick;
  logic [N_CH-1:0]           inv, pwm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= DIV_RST;
      top_q  <= '1;
      lvl_q  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_CTRL:  ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        REG_DIV:   div_q  <= wr_data_i[DIV_W-1:0];
        REG_LEVEL: lvl_q  <= wr_data_i[N_CH*CNT_W-1:0];
        REG_TOP:   top_q  <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // gated divider modes have no gate source here: nonzero mode halts
  assign run = ctrl_q.enable && (ctrl_q.div_mode == 2'b00);
  assign inv = {ctrl_q.inv_b, ctrl_q.inv_a};

  pwm_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  pwm_counter #(.CW(CNT_W), .NCH(N_CH)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (tick),
    .phase_i (ctrl_q.phase_correct),
    .top_i   (top_q),
    .lvl_i   (lvl_q),
    .cnt_o   (cnt),
    .lvl_o   (lvl_act),
    .wrap_o  (wrap_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_channel #(.CW(CNT_W)) i_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .lvl_i  (lvl_act[g]),
      .inv_i  (inv[g]),
      .pwm_o  (pwm[g])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];

  a_r11_mode_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.div_mode != 2'b00) |=> !wrap_o);

  a_r12_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!pwm_a_o && !pwm_b_o && !wrap_o));
endmodule

// File: tb/test_pwm_slice.sv
`timescale 1ns/1ps
module test_pwm_slice;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        pwm_a_o, pwm_b_o, wrap_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #2 clk_i = ~clk_i;

  pwm_slice i_pwm_slice (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .wrap_o(wrap_o)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic configure(input bit pc, input bit ia, input bit ib, input logic [1:0] mode,
                           input logic [11:0] dv, input logic [15:0] top,
                           input logic [15:0] la, input logic [15:0] lb);
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, {20'd0, dv});
    write_reg(2'd2, {lb, la});
    write_reg(2'd3, {16'd0, top});
    write_reg(2'd0, {26'd0, mode, ib, ia, pc, 1'b1});
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!wrap_o);
  endtask

  task automatic measure(input int periods, output int cyc, output int ha, output int hb);
    int w;
    cyc = 0; ha = 0; hb = 0; w = 0;
    do @(negedge clk_i); while (!wrap_o);
    while (w < periods) begin
      @(negedge clk_i);
      cyc++;
      if (pwm_a_o) ha++;
      if (pwm_b_o) hb++;
      if (wrap_o) w++;
    end
  endtask

  task automatic t_reset();
    int wraps = 0;
    check(!pwm_a_o && !pwm_b_o && !wrap_o, "R12 outputs low after reset",
          {pwm_a_o, pwm_b_o, wrap_o}, 0);
    for (int i = 0; i < 30; i++) begin @(negedge clk_i); if (wrap_o) wraps++; end
    check(wraps == 0, "R1 disabled at reset, no wrap", wraps, 0);
  endtask

  task automatic t_normal();
    int c, a, b;
    configure(0, 0, 0, 2'b00, 12'h010, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(c == 40, "R4 trailing-edge period", c, 40);
    check(a == 12, "R6 channel A duty", a, 12);
    check(b == 28, "R6 channel B duty", b, 28);
  endtask

  task automatic t_wrap_width();
    int n;
    configure(0, 0, 0, 2'b00, 12'h010, 16'd9, 16'd3, 16'd7);
    measure(2, n, n, n);
    @(negedge clk_i);
    check(!wrap_o, "R10 wrap pulse one clock", wrap_o, 0);
  endtask

  task automatic t_invert();
    int c, a, b;
    configure(0, 1, 0, 2'b00, 12'h010, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(a == 28, "R7 invert A", a, 28);
    check(b == 28, "R7 B unaffected by A invert", b, 28);
    configure(0, 0, 1, 2'b00, 12'h010, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(a == 12, "R7 A unaffected by B invert", a, 12);
    check(b == 12, "R7 invert B", b, 12);
  endtask

  task automatic t_extremes();
    int c, a, b;
    configure(0, 0, 0, 2'b00, 12'h010, 16'd9, 16'd0, 16'd20);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(a == 0, "R6 level 0 constant low", a, 0);
    check(b == 40, "R6 level above TOP constant high", b, 40);
  endtask

  task automatic t_phase();
    int c, a, b;
    configure(1, 0, 0, 2'b00, 12'h010, 16'd9, 16'd3, 16'd10);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(c == 80, "R5 phase-correct period", c, 80);
    check(a == 24, "R5 phase-correct duty A", a, 24);
    check(b == 80, "R6 phase-correct level above TOP", b, 80);
  endtask

  task automatic t_int_div();
    int c, a, b;
    configure(0, 0, 0, 2'b00, 12'h030, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(2, c, a, b);
    check(c == 60, "R2 integer divider period", c, 60);
    check(a == 18, "R2 integer divider duty", a, 18);
  endtask

  task automatic t_frac_div();
    int c, a, b;
    configure(0, 0, 0, 2'b00, 12'h018, 16'd3, 16'd1, 16'd2);
    measure(2, c, a, b);
    measure(16, c, a, b);
    check(c == 96, "R2 fractional divider 1.5 average", c, 96);
  endtask

  task automatic t_clamp();
    int c, a, b;
    configure(0, 0, 0, 2'b00, 12'h005, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(c == 40, "R3 divider below 1.0 clamps", c, 40);
    configure(0, 0, 0, 2'b00, 12'h000, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    measure(4, c, a, b);
    check(c == 40, "R3 divider zero clamps", c, 40);
  endtask

  task automatic t_shadow();
    int c, a, b, n1, n2;
    configure(0, 0, 0, 2'b00, 12'h010, 16'd9, 16'd3, 16'd7);
    measure(2, c, a, b);
    write_reg(2'd3, 32'd19);
    gap(n1);
    n1 = n1 + 1;
    check(n1 == 10, "R8 old TOP finishes current period", n1, 10);
    gap(n2);
    check(n2 == 20, "R8 new TOP after wrap", n2, 20);
  endtask

  task automatic t_freeze();
    int c, a, b, wraps, chg, n;
    logic a0, b0;
    configure(0, 0, 0, 2'b00, 12'h010, 16'd9, 16'd5, 16'd2);
    measure(2, c, a, b);
    repeat (3) @(negedge clk_i);
    write_reg(2'd0, 32'd0);
    @(negedge clk_i);
    a0 = pwm_a_o; b0 = pwm_b_o;
    wraps = 0; chg = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (wrap_o) wraps++;
      if (pwm_a_o != a0 || pwm_b_o != b0) chg++;
    end
    check(wraps == 0, "R9 disabled, no wrap", wraps, 0);
    check(chg == 0, "R9 disabled, outputs hold", chg, 0);
    write_reg(2'd0, 32'd1);
    gap(n);
    check(n <= 11, "R9 resumes from frozen count", n, 10);
  endtask

  task automatic t_mode();
    int wraps = 0;
    int n;
    configure(0, 0, 0, 2'b01, 12'h010, 16'd9, 16'd3, 16'd7);
    for (int i = 0; i < 40; i++) begin @(negedge clk_i); if (wrap_o) wraps++; end
    check(wraps == 0, "R11 nonzero divider mode halts", wraps, 0);
    write_reg(2'd0, 32'd1);
    gap(n);
    check(n <= 11, "R11 mode 0 counts again", n, 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!pwm_a_o && !pwm_b_o && !wrap_o, "R12 outputs low in reset", 1, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_wrap_width();
    t_invert();
    t_extremes();
    t_phase();
    t_int_div();
    t_frac_div();
    t_clamp();
    t_shadow();
    t_freeze();
    t_mode();
    summary();
  end
endmodule